// File: doc/BRIEF.md
# Eight-Line Receive Scanner with Shared Silo and One-Shot Alarm

This block gathers characters from up to eight serial receive lines into a single shared FIFO silo. It presents the oldest entry as a 16-bit receive word that can only be read. Each line has a one-entry holding slot. A character-valid strobe on an enabled line loads that slot while the scanner is running. Every cycle an arbiter moves one occupied slot into the silo, and the lowest-numbered line goes first. A received break becomes an entry that is flagged as a framing error.

The block also produces three outputs from the silo: a receive-done status, a silo-alarm status and a receive interrupt request. The alarm is one-shot. It fires once when the silo holds the threshold number of entries. It then stays disarmed until a read finds the silo empty. The interrupt follows the alarm when the alarm-enable bit is set, and follows receive-done otherwise. Software-facing control arrives as three control bits, written together, and a separate clear pulse. Per-line receive enables are written through a line-parameter word.

Top module: `rx_scan_silo`

## Requirements
- R1: The receive word is all zeros except for these fields: bit 15 is the valid flag, bit 13 is the framing-error flag, bits 10:8 hold the source line number and bits 7:0 hold the character. Bits 14, 12 and 11 always read zero.
- R2: A break strobe stores an entry that reads with the valid and framing-error bits set, the line number tagged, and a zero character.
- R3: When several holding slots are occupied at once, they enter the silo in ascending line order.
- R4: Receive-done is high exactly when the scanner is on and the silo holds at least one entry.
- R5: While the alarm is armed, a silo holding at least 16 entries sets silo-alarm and disarms it, so the alarm fires only once. A read in the cycle where the alarm would fire takes priority: the alarm stays clear and stays armed.
- R6: A read clears silo-alarm. Only a read that finds the silo empty re-arms the alarm, and such a read returns zero.
- R7: With the scanner off, the receive word reads zero, receive-done is low, silo-alarm clears, reads pop nothing and strobes are ignored. Stored entries survive until the scanner is on again.
- R8: The interrupt request equals the interrupt-enable bit ANDed with the selected condition: silo-alarm when alarm-enable is set, receive-done otherwise.
- R9: A line-parameter write takes the line from bits 2:0 and that line's receive enable from bit 12. A strobe on a disabled line is ignored.
- R10: A clear pulse empties the silo and the holding slots, zeroes the three control bits and the overflow flag, re-arms the alarm and disables every line.
- R11: One read pops exactly one entry. The receive word shows the next entry in the cycle after the read, in arrival order.
- R12: A strobe on a line whose holding slot is still occupied (the silo is full) is dropped and sets a sticky overflow flag. The silo never takes a write while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb | input | 8 | Per-line character-valid strobe |
| line_char | input | 64 | Per-line character, line i in bits 8i+7:8i |
| line_brk | input | 8 | Per-line break flag, qualified by line_stb |
| lp_we | input | 1 | Line-parameter write strobe |
| lp_wdata | input | 16 | Line-parameter word: line in bits 2:0, receive enable in bit 12 |
| ctl_we | input | 1 | Control write strobe |
| ctl_mse | input | 1 | Scanner-on bit to write |
| ctl_rie | input | 1 | Receive-interrupt-enable bit to write |
| ctl_sae | input | 1 | Silo-alarm-enable bit to write |
| ctl_clr | input | 1 | Clear pulse |
| rd_stb | input | 1 | Receive-word read strobe (pops one entry) |
| rx_word | output | 16 | Receive word at the silo head |
| scan_on | output | 1 | Current scanner-on bit |
| rcv_done | output | 1 | Receive-done status |
| silo_alarm | output | 1 | Silo-alarm status |
| rx_irq | output | 1 | Receive interrupt request |
| silo_ovf | output | 1 | Sticky overflow flag |

## Verification
Two functions can fall in the same cycle: the threshold test that sets the alarm, and a read that clears it. The bench pushes the sixteenth entry and holds the read strobe across the exact edge where the alarm would fire. It then expects the alarm to stay low with 15 entries left. A later push back to 16 must fire the alarm, which shows the alarm stayed armed. A second collision, a pop while the full silo is refilled from a held slot, is provoked in the overflow test. There the bench checks that the held character arrives once, in order.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   localparam int WORD_W    = 16;
   localparam int CHAR_W    = 8;
   localparam int VALID_BIT = 15;
   localparam int FRAME_BIT = 13;
   localparam int LINE_LSB  = 8;
   localparam int ENAB_BIT  = 12;
   localparam int MAX_LINES = 8;
endpackage

// File: rtl/rxs_pick.sv
module rxs_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx   = '0;
      any   = 1'b0;
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
      if (any) grant[idx] = 1'b1;
   end

   p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/rxs_silo.sv
module rxs_silo #(
   parameter int W     = 12,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW    = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("rxs_silo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;

   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   p_pop_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !flush) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/rx_scan_silo.sv
module rx_scan_silo
   import rxs_pkg::*;
#(
   parameter int NLINES      = 8,
   parameter int SILO_DEPTH  = 64,
   parameter int ALARM_LEVEL = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NLINES-1:0]          line_stb,
   input  logic [NLINES*CHAR_W-1:0]   line_char,
   input  logic [NLINES-1:0]          line_brk,
   input  logic                       lp_we,
   input  logic [WORD_W-1:0]          lp_wdata,
   input  logic                       ctl_we,
   input  logic                       ctl_mse,
   input  logic                       ctl_rie,
   input  logic                       ctl_sae,
   input  logic                       ctl_clr,
   input  logic                       rd_stb,
   output logic [WORD_W-1:0]          rx_word,
   output logic                       scan_on,
   output logic                       rcv_done,
   output logic                       silo_alarm,
   output logic                       rx_irq,
   output logic                       silo_ovf
);
   localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1;
   localparam int ENT_W  = 1 + LINE_W + CHAR_W;
   localparam int CNT_W  = $clog2(SILO_DEPTH + 1);

   if (NLINES < 2 || NLINES > MAX_LINES) begin : g_bad_lines
      $error("rx_scan_silo: NLINES out of range");
   end
   if (ALARM_LEVEL < 1 || ALARM_LEVEL > SILO_DEPTH) begin : g_bad_alarm
      $error("rx_scan_silo: ALARM_LEVEL must lie within the silo depth");
   end

   // control bits
   logic mse_q, rie_q, sae_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mse_q <= 1'b0; rie_q <= 1'b0; sae_q <= 1'b0;
      end else if (ctl_clr) begin
         mse_q <= 1'b0; rie_q <= 1'b0; sae_q <= 1'b0;
      end else if (ctl_we) begin
         mse_q <= ctl_mse; rie_q <= ctl_rie; sae_q <= ctl_sae;
      end
   end

   // silo and arbiter wiring
   logic [NLINES-1:0]  hold_v;
   logic [CHAR_W-1:0]  hold_c [NLINES];
   logic [NLINES-1:0]  hold_b;
   logic [NLINES-1:0]  en_q;
   logic [NLINES-1:0]  drop;
   logic [NLINES-1:0]  grant;
   logic [LINE_W-1:0]  pick_idx;
   logic               pick_any;
   logic               s_empty, s_full, s_pop;
   logic [ENT_W-1:0]   s_din, s_dout;
   logic [CNT_W-1:0]   s_count;

   wire [LINE_W-1:0] lp_line = lp_wdata[LINE_W-1:0];
   wire unused_lp = ^{lp_wdata[WORD_W-1:ENAB_BIT+1], lp_wdata[ENAB_BIT-1:LINE_W]};

   // per-line holding slot and receive enable
   for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
      wire cap = line_stb[gi] & en_q[gi] & mse_q;
      assign drop[gi] = cap & hold_v[gi] & ~grant[gi];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[gi] <= 1'b0;
         end else if (ctl_clr) begin
            en_q[gi] <= 1'b0;
         end else if (lp_we && lp_line == LINE_W'(gi)) begin
            en_q[gi] <= lp_wdata[ENAB_BIT];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_v[gi] <= 1'b0;
            hold_b[gi] <= 1'b0;
            hold_c[gi] <= '0;
         end else if (ctl_clr) begin
            hold_v[gi] <= 1'b0;
         end else if (cap && !drop[gi]) begin
            hold_v[gi] <= 1'b1;
            hold_b[gi] <= line_brk[gi];
            hold_c[gi] <= line_brk[gi] ? '0 : line_char[gi*CHAR_W +: CHAR_W];
         end else if (grant[gi]) begin
            hold_v[gi] <= 1'b0;
         end
      end
   end

   rxs_pick #(.N(NLINES), .IDX_W(LINE_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (s_full ? '0 : hold_v),
      .grant (grant),
      .idx   (pick_idx),
      .any   (pick_any)
   );

   assign s_din = {hold_b[pick_idx], pick_idx, hold_c[pick_idx]};
   assign s_pop = rd_stb & mse_q & ~s_empty & ~ctl_clr;

   rxs_silo #(.W(ENT_W), .DEPTH(SILO_DEPTH)) u_silo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (ctl_clr),
      .push  (pick_any & ~ctl_clr),
      .din   (s_din),
      .pop   (s_pop),
      .dout  (s_dout),
      .empty (s_empty),
      .full  (s_full),
      .count (s_count)
   );

   // one-shot alarm
   logic armed_q, sa_q, ovf_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         sa_q    <= 1'b0;
      end else if (ctl_clr) begin
         armed_q <= 1'b1;
         sa_q    <= 1'b0;
      end else if (!mse_q) begin
         sa_q    <= 1'b0;
      end else if (rd_stb) begin
         sa_q    <= 1'b0;
         if (s_empty) armed_q <= 1'b1;
      end else if (armed_q && s_count >= CNT_W'(ALARM_LEVEL)) begin
         sa_q    <= 1'b1;
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (ctl_clr) ovf_q <= 1'b0;
      else if (|drop)   ovf_q <= 1'b1;
   end

   // outputs
   always_comb begin
      rx_word = '0;
      if (mse_q && !s_empty) begin
         rx_word[VALID_BIT]               = 1'b1;
         rx_word[FRAME_BIT]               = s_dout[ENT_W-1];
         rx_word[LINE_LSB +: LINE_W]      = s_dout[CHAR_W +: LINE_W];
         rx_word[CHAR_W-1:0]              = s_dout[CHAR_W-1:0];
      end
   end

   assign scan_on    = mse_q;
   assign rcv_done   = mse_q & ~s_empty;
   assign silo_alarm = sa_q;
   assign rx_irq     = rie_q & (sae_q ? sa_q : rcv_done);
   assign silo_ovf   = ovf_q;

   p_alarm_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mse_q && !ctl_clr && !rd_stb && armed_q && s_count >= CNT_W'(ALARM_LEVEL))
      |=> (silo_alarm && !armed_q));
   p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mse_q && s_empty && !ctl_clr) |=> (armed_q && !silo_alarm));
   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (rie_q && (silo_alarm || rcv_done)));
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clr |=> (!scan_on && s_empty && !silo_ovf && en_q == '0));
endmodule

// File: tb/rx_scan_silo_tb.sv
module rx_scan_silo_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]   line_stb = '0;
   logic [N*8-1:0] line_char = '0;
   logic [N-1:0]   line_brk = '0;
   logic lp_we = 1'b0;
   logic [15:0] lp_wdata = '0;
   logic ctl_we = 1'b0, ctl_mse = 1'b0, ctl_rie = 1'b0, ctl_sae = 1'b0, ctl_clr = 1'b0;
   logic rd_stb = 1'b0;
   logic [15:0] rx_word;
   logic scan_on, rcv_done, silo_alarm, rx_irq, silo_ovf;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_scan_silo u_dut (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_char(line_char),
      .line_brk(line_brk), .lp_we(lp_we), .lp_wdata(lp_wdata), .ctl_we(ctl_we),
      .ctl_mse(ctl_mse), .ctl_rie(ctl_rie), .ctl_sae(ctl_sae), .ctl_clr(ctl_clr),
      .rd_stb(rd_stb), .rx_word(rx_word), .scan_on(scan_on), .rcv_done(rcv_done),
      .silo_alarm(silo_alarm), .rx_irq(rx_irq), .silo_ovf(silo_ovf)
   );

   // {line[2:0], brk, char[7:0], expected word[15:0]}
   localparam logic [27:0] VEC [8] = '{
      {3'd0, 1'b0, 8'h41, 16'h8041},
      {3'd7, 1'b0, 8'hFF, 16'h87FF},
      {3'd3, 1'b1, 8'h5A, 16'hA300},
      {3'd5, 1'b0, 8'h00, 16'h8500},
      {3'd1, 1'b1, 8'h00, 16'hA100},
      {3'd6, 1'b0, 8'h7E, 16'h867E},
      {3'd2, 1'b0, 8'h80, 16'h8280},
      {3'd4, 1'b0, 8'hC3, 16'h84C3}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ctl_write(input logic m, input logic r, input logic s);
      @(negedge clk);
      ctl_we = 1'b1; ctl_mse = m; ctl_rie = r; ctl_sae = s;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic lp_write(input int line, input logic en);
      @(negedge clk);
      lp_we = 1'b1;
      lp_wdata = 16'hE000 | (16'(en) << 12) | 16'(line);
      @(negedge clk);
      lp_we = 1'b0;
   endtask

   task automatic send(input int line, input logic [7:0] c, input logic b);
      @(negedge clk);
      line_stb[line] = 1'b1;
      line_brk[line] = b;
      line_char[line*8 +: 8] = c;
      @(negedge clk);
      line_stb = '0;
      line_brk = '0;
   endtask

   task automatic rd();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // reset state
      chk("R4 reset", {rx_word, scan_on, rcv_done, silo_alarm, rx_irq}, 16'h0);
      chk("R12 reset ovf", 16'(silo_ovf), 16'h0);

      ctl_write(1'b1, 1'b0, 1'b0);
      for (int l = 0; l < N; l++) lp_write(l, 1'b1);

      // R1/R2/R4/R11: format table
      for (int v = 0; v < 8; v++) begin
         send(int'(VEC[v][27:25]), VEC[v][23:16], VEC[v][24]);
         tick(1);
         chk("R1 R2 word", rx_word, VEC[v][15:0]);
         chk("R4 done set", 16'(rcv_done), 16'h1);
         rd();
         chk("R11 popped", rx_word, 16'h0);
         chk("R4 done clear", 16'(rcv_done), 16'h0);
      end

      // R3: simultaneous lines
      @(negedge clk);
      line_stb = 8'b0110_0100;
      line_char[5*8 +: 8] = 8'h55;
      line_char[2*8 +: 8] = 8'h22;
      line_char[6*8 +: 8] = 8'h66;
      @(negedge clk);
      line_stb = '0;
      tick(4);
      chk("R3 first", rx_word, 16'h8222); rd();
      chk("R3 second", rx_word, 16'h8555); rd();
      chk("R3 third", rx_word, 16'h8666); rd();
      chk("R3 empty", rx_word, 16'h0000);

      // R8 with alarm-enable off: irq follows done
      ctl_write(1'b1, 1'b1, 1'b0);
      send(0, 8'h11, 1'b0);
      tick(1);
      chk("R8 irq from done", 16'(rx_irq), 16'h1);
      rd();
      chk("R8 irq drops", 16'(rx_irq), 16'h0);

      // R5/R6 alarm, with read colliding with threshold
      ctl_write(1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 15; i++) send(0, 8'(i), 1'b0);
      tick(3);
      chk("R8 sae selects alarm", {15'h0, rx_irq}, 16'h0);
      chk("R5 below level", 16'(silo_alarm), 16'h0);
      send(0, 8'd15, 1'b0);
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      tick(2);
      chk("R5 read wins collision", 16'(silo_alarm), 16'h0);
      send(0, 8'd16, 1'b0);
      tick(3);
      chk("R5 alarm fires", 16'(silo_alarm), 16'h1);
      chk("R8 irq from alarm", 16'(rx_irq), 16'h1);
      send(0, 8'd17, 1'b0);
      tick(2);
      rd();
      chk("R6 read clears alarm", 16'(silo_alarm), 16'h0);
      tick(3);
      chk("R5 one-shot", 16'(silo_alarm), 16'h0);
      ctl_write(1'b1, 1'b1, 1'b0);
      chk("R8 back to done", 16'(rx_irq), 16'h1);
      for (int i = 0; i < 16; i++) begin
         if (i == 0 || i == 15) chk("R11 order", rx_word, 16'h8000 | 16'(i + 2));
         rd();
      end
      chk("R6 drained", rx_word, 16'h0);
      ctl_write(1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 16; i++) send(1, 8'(i), 1'b0);
      tick(3);
      chk("R6 not re-armed", 16'(silo_alarm), 16'h0);
      for (int i = 0; i < 16; i++) rd();
      rd();
      chk("R6 empty read zero", rx_word, 16'h0);
      for (int i = 0; i < 16; i++) send(1, 8'(i), 1'b0);
      tick(3);
      chk("R6 re-armed fires", 16'(silo_alarm), 16'h1);
      for (int i = 0; i < 16; i++) rd();
      rd();

      // R9: line disable
      ctl_write(1'b1, 1'b0, 1'b0);
      lp_write(3, 1'b0);
      send(3, 8'h33, 1'b0);
      tick(3);
      chk("R9 disabled ignored", {rx_word[15:1], rcv_done}, 16'h0);
      lp_write(3, 1'b1);
      send(3, 8'h11, 1'b0);
      tick(1);
      chk("R9 enabled", rx_word, 16'h8311);
      rd();

      // R7: scanner off
      send(1, 8'h31, 1'b0);
      tick(1);
      ctl_write(1'b0, 1'b1, 1'b0);
      chk("R7 word zero", rx_word, 16'h0);
      chk("R7 done/irq low", {14'h0, rcv_done, rx_irq}, 16'h0);
      send(1, 8'h77, 1'b0);
      rd();
      ctl_write(1'b1, 1'b0, 1'b0);
      chk("R7 kept entry", rx_word, 16'h8131);
      rd();
      tick(2);
      chk("R7 strobe ignored", rx_word, 16'h0);

      // R12: overflow
      for (int i = 0; i < 66; i++) send(0, 8'(i), 1'b0);
      chk("R12 ovf sticky", 16'(silo_ovf), 16'h1);
      for (int i = 0; i < 65; i++) begin
         tick(1);
         if (i == 0 || i == 63 || i == 64) chk("R12 R11 order", rx_word, 16'h8000 | 16'(i));
         rd();
      end
      tick(2);
      chk("R12 dropped char", rx_word, 16'h0);

      // R10: clear
      send(2, 8'h22, 1'b0);
      tick(1);
      @(negedge clk);
      ctl_clr = 1'b1;
      @(negedge clk);
      ctl_clr = 1'b0;
      chk("R10 cleared", {rx_word[15:3], scan_on, rcv_done, silo_ovf}, 16'h0);
      ctl_write(1'b1, 1'b0, 1'b0);
      chk("R10 silo empty", rx_word, 16'h0);
      send(2, 8'h44, 1'b0);
      tick(2);
      chk("R10 lines off", rx_word, 16'h0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule